// File: doc/BRIEF.md
# Snapshot-Read Free-Running Timer

This block keeps a wide counter that advances by one on every clock edge after reset and never stops. Software cannot see the running value directly. It reads a stored copy through two register words, one for the lower half and one for the upper half. A single write to a command register takes that copy, so both halves always belong to the same count, however far apart in time software reads them.

The command register has two action bits, capture and zero, and a set of general bits. An action bit takes effect during the write that sets it and is never stored, so it always reads back as zero. The general bits are stored and read back as written. Software may also load either half of the copy directly. None of these writes changes the running counter.

The port is a plain one-cycle register port. A write strobe, a byte address and write data are sampled on the clock edge. Read data follows the address combinationally. The counter width, the word width and the three offsets are parameters, and elaboration checks that the counter is exactly two words wide.

Top module: `fst_timer`

## Requirements
- R1: During and immediately after reset, the lower word (offset 0x0), the upper word (offset 0x4) and the command register (offset 0x8) all read zero.
- R2: The running counter is zero after reset and increments by one at every clock edge, wrapping modulo 2^CNT_W. A capture issued at edge k stores the count held just before that edge, which is k-1 edges after the first edge out of reset.
- R3: A write to offset 0x8 with bit 1 set stores the whole counter into the copy at that single edge. The lower word then holds bits REG_W-1:0 and the upper word holds the next REG_W bits, including across a carry out of the lower half.
- R4: Command bit 1 (capture) always reads back as zero.
- R5: A write to offset 0x8 with bit 0 set zeroes both words of the copy, and bit 0 always reads back as zero.
- R6: A command write that sets both bit 1 and bit 0 leaves both words at zero.
- R7: A write to offset 0x0 or 0x4 loads the write data into the lower or upper word. The other word is left unchanged.
- R8: Direct loads, zero commands and capture commands do not disturb the running counter. A later capture returns the uninterrupted count.
- R9: Command register bits other than 1 and 0 are stored on a write to offset 0x8 and read back unchanged. A command write with both action bits clear leaves the copy unchanged.
- R10: Writes to any other offset change nothing, and reads from any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data for the register at bus_addr (combinational) |

## Verification
The assertions assume that the strobe, address and data are driven to known values from the first clock edge. They also assume that each write concerns exactly one address during its cycle. The stimulus meets this by changing the bus only just after a rising edge and by holding the strobe low whenever it is idle. The bench runs the block at a reduced width so that carries out of the lower half and a full wrap of the counter happen within the run. Capture, zero, mixed commands, direct loads and unmapped writes are interleaved at varying distances from those carries.

// File: rtl/fst_pkg.sv
package fst_pkg;

   typedef enum logic [1:0] {
      FST_SEL_LO   = 2'd0,
      FST_SEL_HI   = 2'd1,
      FST_SEL_CTRL = 2'd2,
      FST_SEL_NONE = 2'd3
   } fst_sel_e;

   typedef struct packed {
      logic wr_lo;
      logic wr_hi;
      logic wr_ctrl;
   } fst_wr_s;

endpackage

// File: rtl/fst_counter.sv
module fst_counter #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic             seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_q + ONE;
         seen_q <= 1'b1;
      end
   end

   assign cnt = cnt_q;

   // R2: one step per clock, wrapping
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> (cnt_q == $past(cnt_q) + ONE));

endmodule

// File: rtl/fst_decode.sv
module fst_decode
   import fst_pkg::*;
#(
   parameter int               ADDR_W   = 4,
   parameter int               REG_W    = 32,
   parameter logic [ADDR_W-1:0] LO_OFS  = 'h0,
   parameter logic [ADDR_W-1:0] HI_OFS  = 'h4,
   parameter logic [ADDR_W-1:0] CTRL_OFS = 'h8
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  lo_val,
   input  logic [REG_W-1:0]  hi_val,
   input  logic [REG_W-1:0]  ctrl_val,
   output fst_wr_s           wr_sel,
   output logic [REG_W-1:0]  rdata
);

   fst_sel_e sel;

   always_comb begin
      if (addr == LO_OFS)        sel = FST_SEL_LO;
      else if (addr == HI_OFS)   sel = FST_SEL_HI;
      else if (addr == CTRL_OFS) sel = FST_SEL_CTRL;
      else                       sel = FST_SEL_NONE;
   end

   always_comb begin
      wr_sel.wr_lo   = wr && (sel == FST_SEL_LO);
      wr_sel.wr_hi   = wr && (sel == FST_SEL_HI);
      wr_sel.wr_ctrl = wr && (sel == FST_SEL_CTRL);
   end

   always_comb begin
      unique case (sel)
         FST_SEL_LO:   rdata = lo_val;
         FST_SEL_HI:   rdata = hi_val;
         FST_SEL_CTRL: rdata = ctrl_val;
         default:      rdata = '0;
      endcase
   end

endmodule

// File: rtl/fst_snapshot.sv
module fst_snapshot #(
   parameter int CNT_W = 64,
   parameter int REG_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   cnt,
   input  logic               cmd_latch,
   input  logic               cmd_clear,
   input  logic [NWORDS-1:0]  wr_word,
   input  logic [REG_W-1:0]   wdata,
   output logic [CNT_W-1:0]   snap
);

   localparam int NWORDS = CNT_W / REG_W;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic [REG_W-1:0] word_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q <= '0;
         else if (cmd_clear)
            word_q <= '0;
         else if (cmd_latch)
            word_q <= cnt[w*REG_W +: REG_W];
         else if (wr_word[w])
            word_q <= wdata;
      end

      assign snap[w*REG_W +: REG_W] = word_q;
   end

   // R3: capture stores the whole count in one edge
   p_latch_whole_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_latch && !cmd_clear) |=> (snap == $past(cnt)));

   // R5 and R6: zero command wins and empties both words
   p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_clear |=> (snap == '0));

   // R10: without a command or a direct load the copy holds
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_latch || cmd_clear || (|wr_word)) |=> $stable(snap));

endmodule

// File: rtl/fst_timer.sv
module fst_timer
   import fst_pkg::*;
#(
   parameter int                CNT_W     = 64,
   parameter int                REG_W     = 32,
   parameter int                ADDR_W    = 4,
   parameter logic [ADDR_W-1:0] LO_OFS    = 'h0,
   parameter logic [ADDR_W-1:0] HI_OFS    = 'h4,
   parameter logic [ADDR_W-1:0] CTRL_OFS  = 'h8,
   parameter int                LATCH_BIT = 1,
   parameter int                CLEAR_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata
);

   localparam int NWORDS = CNT_W / REG_W;
   localparam logic [REG_W-1:0] CMD_MASK =
      (REG_W'(1) << LATCH_BIT) | (REG_W'(1) << CLEAR_BIT);

   if (CNT_W != 2 * REG_W) begin : g_bad_width
      $error("fst_timer: CNT_W must be twice REG_W");
   end
   if (LATCH_BIT == CLEAR_BIT || LATCH_BIT >= REG_W || CLEAR_BIT >= REG_W) begin : g_bad_bits
      $error("fst_timer: command bits must be distinct and inside a word");
   end
   if (LO_OFS == HI_OFS || LO_OFS == CTRL_OFS || HI_OFS == CTRL_OFS) begin : g_bad_ofs
      $error("fst_timer: register offsets must differ");
   end

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  snap;
   logic [REG_W-1:0]  ctrl_q;
   fst_wr_s           wr_sel;
   logic              cmd_latch;
   logic              cmd_clear;
   logic [NWORDS-1:0] wr_word;

   fst_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt)
   );

   fst_decode #(
      .ADDR_W   (ADDR_W),
      .REG_W    (REG_W),
      .LO_OFS   (LO_OFS),
      .HI_OFS   (HI_OFS),
      .CTRL_OFS (CTRL_OFS)
   ) u_decode (
      .wr       (bus_wr),
      .addr     (bus_addr),
      .lo_val   (snap[REG_W-1:0]),
      .hi_val   (snap[CNT_W-1:REG_W]),
      .ctrl_val (ctrl_q),
      .wr_sel   (wr_sel),
      .rdata    (bus_rdata)
   );

   assign cmd_latch = wr_sel.wr_ctrl && bus_wdata[LATCH_BIT];
   assign cmd_clear = wr_sel.wr_ctrl && bus_wdata[CLEAR_BIT];
   assign wr_word   = {wr_sel.wr_hi, wr_sel.wr_lo};

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_sel.wr_ctrl)
         ctrl_q <= bus_wdata & ~CMD_MASK;
   end

   fst_snapshot #(
      .CNT_W (CNT_W),
      .REG_W (REG_W)
   ) u_snapshot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (cnt),
      .cmd_latch (cmd_latch),
      .cmd_clear (cmd_clear),
      .wr_word   (wr_word),
      .wdata     (bus_wdata),
      .snap      (snap)
   );

   // R4: the capture bit never reads back as one
   p_latch_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == CTRL_OFS) |-> (bus_rdata[LATCH_BIT] == 1'b0));

endmodule

// File: tb/fst_timer_bench.sv
module fst_timer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int REG_W      = 8;
   localparam int ADDR_W     = 4;
   localparam longint CMASK  = (64'd1 << CNT_W) - 1;
   localparam longint WMASK  = (64'd1 << REG_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [REG_W-1:0]  bus_wdata = '0;
   logic [REG_W-1:0]  bus_rdata;

   int     n_checks = 0;
   int     n_fail   = 0;
   bit     chk_en   = 1'b0;
   bit     done     = 1'b0;
   string  cur_req  = "R1";

   longint cnt_m  = 0;
   longint snap_m = 0;
   longint ctrl_m = 0;

   fst_timer #(
      .CNT_W  (CNT_W),
      .REG_W  (REG_W),
      .ADDR_W (ADDR_W)
   ) u_fst_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model, advanced on every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         cnt_m = 0; snap_m = 0; ctrl_m = 0;
      end else begin
         if (bus_wr) begin
            case (bus_addr)
               4'h0: snap_m = (snap_m & ~WMASK) | longint'(bus_wdata);
               4'h4: snap_m = (snap_m & WMASK) | (longint'(bus_wdata) << REG_W);
               4'h8: begin
                  ctrl_m = longint'(bus_wdata) & ~64'h3;
                  if (bus_wdata[1]) snap_m = cnt_m;
                  if (bus_wdata[0]) snap_m = 0;
               end
               default: ;
            endcase
         end
         cnt_m = (cnt_m + 1) & CMASK;
      end
   end

   // compare the addressed register on every falling edge
   always @(negedge clk) begin
      if (chk_en && !done) begin
         longint exp_v;
         case (bus_addr)
            4'h0:    exp_v = snap_m & WMASK;
            4'h4:    exp_v = (snap_m >> REG_W) & WMASK;
            4'h8:    exp_v = ctrl_m & WMASK;
            default: exp_v = 0;
         endcase
         n_checks++;
         if (longint'(bus_rdata) != exp_v) begin
            n_fail++;
            $display("FAIL %s addr=%0h actual=%0h expected=%0h t=%0t",
                     cur_req, bus_addr, bus_rdata, exp_v, $time);
         end
      end
   end

   task automatic step(input bit wr, input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
      @(posedge clk); #1;
      bus_wr = wr; bus_addr = a; bus_wdata = d;
   endtask

   task automatic read_all();
      step(0, 4'h0, '0);
      step(0, 4'h4, '0);
      step(0, 4'h8, '0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 4'h8, '0);
   endtask

   initial begin
      // R1: reset values
      cur_req = "R1";
      repeat (2) @(posedge clk);
      #1 chk_en = 1'b1;
      read_all();
      step(0, 4'h0, '0);
      rst_n = 1'b1;
      read_all();

      // R2: capture after a known delay
      cur_req = "R2";
      idle(37);
      step(1, 4'h8, 8'h02);
      read_all();

      // R3: repeated captures across carries out of the lower word
      cur_req = "R3";
      for (int k = 0; k < 90; k++) begin
         step(1, 4'h8, 8'h02);
         step(0, 4'h0, '0);
         step(0, 4'h4, '0);
         idle(k % 5);
      end

      // R4: capture bit reads zero
      cur_req = "R4";
      step(1, 4'h8, 8'h06);
      step(0, 4'h8, '0);

      // R5: zero command
      cur_req = "R5";
      step(1, 4'h8, 8'h01);
      read_all();

      // R6: both action bits at once
      cur_req = "R6";
      step(1, 4'h8, 8'h02);
      step(1, 4'h8, 8'h03);
      read_all();

      // R7: direct loads of each word
      cur_req = "R7";
      step(1, 4'h0, 8'hA5);
      read_all();
      step(1, 4'h4, 8'h3C);
      read_all();

      // R9: general bits stored, copy left alone
      cur_req = "R9";
      step(1, 4'h8, 8'hF4);
      read_all();
      step(1, 4'h8, 8'hFF);
      read_all();
      step(1, 4'h0, 8'h5A);
      step(1, 4'h8, 8'h80);
      read_all();

      // R10: unmapped offsets
      cur_req = "R10";
      step(1, 4'hC, 8'hFF);
      step(0, 4'hC, '0);
      step(1, 4'h1, 8'h03);
      step(0, 4'h1, '0);
      step(1, 4'h9, 8'h02);
      read_all();

      // R8: running count undisturbed, then a full wrap
      cur_req = "R8";
      step(1, 4'h8, 8'h02);
      read_all();
      idle(66000);
      step(1, 4'h8, 8'h02);
      read_all();
      step(1, 4'h4, 8'h77);
      step(1, 4'h8, 8'h01);
      idle(300);
      step(1, 4'h8, 8'h02);
      read_all();

      step(0, 4'h0, '0);
      @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule